// File: doc/BRIEF.md
# ADC Conversion Burst Sequencer

This block drives an external analog-to-digital converter core so that a single start request yields a burst of exactly eight conversions. Software programs it through a small register write port. Hardware can also request a burst with a rising edge on an asynchronous trigger pin, which is synchronized inside the block. Before the first conversion the sequencer waits a programmable number of ticks of a slow 32 kHz time base, and it can repeat that wait between conversions. Each conversion is a handshake with the core: a start pulse that carries a channel number, then a done pulse that carries the result. The sequencer forwards each result with its slot index and a write strobe.

A burst either sweeps channels 0 to 7 or converts one chosen channel eight times. A calibration burst runs the same eight handshakes with a calibration flag and forwards no results. When a burst ends, the block sets a sticky done flag, and a mask gates the flag onto the interrupt line. At most two requests wait behind the running burst. A self-clearing core reset returns the sequencer to idle and keeps the programmed settings.

Register map, with `cfgAddr` 0 for control and 1 for delay. Control word bits: 0 start, 1 calibrate, 2 single-channel mode, 3 gap enable, 4 core reset, 5 done mask, 6 done-flag clear, and the channel select starting at bit 8. The delay word carries the delay code in its low bits.

Top module: `adc_burst_seq`

## Requirements
- R1: Every burst issues exactly 8 conversion starts. Result slots are reported in the order 0,1,...,7, and each `resWe` pulse follows the core's `convDone`.
- R2: With control bit 2 clear (sweep mode), the conversions use channels 0 to 7 in ascending order, whatever value the channel-select field holds.
- R3: With control bit 2 set (single-channel mode), all 8 conversions use the channel in the select field (bits 8 and up).
- R4: A burst is requested by writing 1 to control bit 0 or by a rising edge on `trigIn`. `ascBit` reads 1 from the request until the last queued burst completes, and then clears itself.
- R5: The first conversion of a burst starts only after delay code + 1 ticks of `tick32k`, so the wait is 1 to 256 ticks. The reset value of the code is 0, which gives 1 tick.
- R6: With control bit 3 set, the same code + 1 tick wait separates each `convDone` from the next start. With bit 3 clear, the next start follows `convDone` with no tick wait.
- R7: A burst launched while `calBit` (control bit 1) is 1 flags every start with `convCal` and produces no `resWe`. `calBit` clears at the end of that burst, and the done flag is still set.
- R8: The end of every burst sets `doneFlag`. `irq` equals `doneFlag` while control bit 5 is 0 and is 0 while it is 1. Writing 1 to control bit 6 clears `doneFlag`.
- R9: Up to 2 requests wait behind the running burst and run one after another. A request that arrives while both wait slots are full is dropped.
- R10: Writing 1 to control bit 4 gives a one-cycle `coreRst` pulse. It returns the sequencer to idle, empties the request queue, and clears `ascBit` and `calBit`. The delay, mode, gap, mask and channel settings are kept.
- R11: After reset, `ascBit`, `calBit`, `doneFlag`, `irq`, `convStart`, `convCal`, `resWe` and `coreRst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick32k | input | 1 | One-cycle strobe from the 32 kHz time base |
| trigIn | input | 1 | Asynchronous hardware trigger; a rising edge requests a burst |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 1 | Register select: 0 control, 1 delay |
| cfgWdata | input | 16 | Register write data |
| convStart | output | 1 | Start pulse to the converter core |
| convChan | output | 3 | Channel to convert, valid with convStart |
| convCal | output | 1 | Calibration flag, valid with convStart |
| convDone | input | 1 | Conversion complete pulse from the core |
| convData | input | 10 | Conversion result, valid with convDone |
| resWe | output | 1 | Result write strobe |
| resSlot | output | 3 | Slot index 0 to 7 of the result |
| resData | output | 10 | Forwarded result |
| ascBit | output | 1 | Burst active or pending status |
| calBit | output | 1 | Calibration request bit |
| doneFlag | output | 1 | Sticky burst-complete flag |
| irq | output | 1 | Masked done interrupt |
| coreRst | output | 1 | One-cycle core reset pulse |

## Verification
The bench counts time-base ticks between a request or a `convDone` and the next start, so an off-by-one delay shows up as a tick count that is one too low or one too high. It also catches a gap wait that is skipped or inserted when it should not be. Four back-to-back start writes probe the queue. A design that drops a request too early runs fewer than 24 conversions, and one that overruns its queue runs more. A calibration burst must write no result and must clear its own bit. A core reset issued in the middle of a gap wait, with a request queued, must stop all further starts while the programmed delay survives. A sweep burst runs with a nonzero channel select, so a design that does not ignore that field reports the wrong channels.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_ISSUE,
    SEQ_CONV
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;     // pop a request, latch burst settings, slot to 0
    logic loadDelay;  // load delay counter from the programmed code
    logic countDown;  // one tick consumed
    logic issue;      // send a start to the core
    logic capture;    // result returned by the core
    logic advance;    // move to next slot
    logic finish;     // burst complete
  } seqStrobe_t;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_DELAY = 1;

  localparam int BIT_START  = 0;
  localparam int BIT_CAL    = 1;
  localparam int BIT_SINGLE = 2;
  localparam int BIT_GAP    = 3;
  localparam int BIT_RST    = 4;
  localparam int BIT_MASK   = 5;
  localparam int BIT_CLR    = 6;
  localparam int CHAN_LSB   = 8;

endpackage

// File: rtl/adc_burst_ctrl.sv
module adc_burst_ctrl
  import adc_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       tick,
  input  logic       pendValid,
  input  logic       delayZero,
  input  logic       lastSlot,
  input  logic       gapEn,
  input  logic       convDone,
  output seqStrobe_t strb,
  output logic       seqBusy
);

  seqState_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    if (!softRst) begin
      case (state)
        SEQ_IDLE: begin
          if (pendValid) begin
            strb.launch    = 1'b1;
            strb.loadDelay = 1'b1;
            stateNxt       = SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (tick) begin
            if (delayZero) stateNxt = SEQ_ISSUE;
            else           strb.countDown = 1'b1;
          end
        end
        SEQ_ISSUE: begin
          strb.issue = 1'b1;
          stateNxt   = SEQ_CONV;
        end
        SEQ_CONV: begin
          if (convDone) begin
            strb.capture = 1'b1;
            if (lastSlot) begin
              strb.finish = 1'b1;
              stateNxt    = SEQ_IDLE;
            end else begin
              strb.advance = 1'b1;
              if (gapEn) begin
                strb.loadDelay = 1'b1;
                stateNxt       = SEQ_WAIT;
              end else begin
                stateNxt = SEQ_ISSUE;
              end
            end
          end
        end
        default: stateNxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= SEQ_IDLE;
    else if (softRst) state <= SEQ_IDLE;
    else              state <= stateNxt;
  end

  assign seqBusy = (state != SEQ_IDLE);

  AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (state == SEQ_IDLE)); // R10

  AST_WAIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_WAIT && !tick && !softRst) |=> (state == SEQ_WAIT)); // R5

endmodule

// File: rtl/adc_burst_dpath.sv
module adc_burst_dpath
  import adc_burst_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int DATA_W      = 10,
  parameter int DELAY_W     = 8,
  parameter int QUEUE_DEPTH = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         trigIn,
  input  logic                         cfgWe,
  input  logic                         cfgAddr,
  input  logic [REG_W-1:0]             cfgWdata,
  input  logic                         convDone,
  input  logic [DATA_W-1:0]            convData,
  input  seqStrobe_t                   strb,
  input  logic                         seqBusy,
  output logic                         softRst,
  output logic                         pendValid,
  output logic                         delayZero,
  output logic                         lastSlot,
  output logic                         gapEn,
  output logic                         convStart,
  output logic [$clog2(NUM_SLOTS)-1:0] convChan,
  output logic                         convCal,
  output logic                         resWe,
  output logic [$clog2(NUM_SLOTS)-1:0] resSlot,
  output logic [DATA_W-1:0]            resData,
  output logic                         ascBit,
  output logic                         calBit,
  output logic                         doneFlag,
  output logic                         irq
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [CNT_W-1:0]  Q_FULL    = CNT_W'(QUEUE_DEPTH);

  logic wrCtrl, wrDelay;
  assign wrCtrl  = cfgWe && (cfgAddr == 1'(ADDR_CTRL));
  assign wrDelay = cfgWe && (cfgAddr == 1'(ADDR_DELAY));

  logic unusedWdata;
  assign unusedWdata = ^{cfgWdata[7], cfgWdata[REG_W-1:CHAN_LSB+SLOT_W],
                         cfgWdata[REG_W-1:DELAY_W]};

  // programmed settings
  logic              singleCfg, maskCfg;
  logic [SLOT_W-1:0] chanCfg;
  logic [DELAY_W-1:0] delayCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleCfg <= 1'b0;
      gapEn     <= 1'b0;
      maskCfg   <= 1'b0;
      chanCfg   <= '0;
      delayCfg  <= '0;
    end else begin
      if (wrCtrl) begin
        singleCfg <= cfgWdata[BIT_SINGLE];
        gapEn     <= cfgWdata[BIT_GAP];
        maskCfg   <= cfgWdata[BIT_MASK];
        chanCfg   <= cfgWdata[CHAN_LSB +: SLOT_W];
      end
      if (wrDelay) delayCfg <= cfgWdata[DELAY_W-1:0];
    end
  end

  // self-clearing core reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softRst <= 1'b0;
    else       softRst <= wrCtrl && cfgWdata[BIT_RST];
  end

  // trigger synchronizer and edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   trigPrev, trigEdge;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else if (i == 0) syncQ[i] <= trigIn;
        else             syncQ[i] <= syncQ[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= syncQ[SYNC_STAGES-1];
  end
  assign trigEdge = syncQ[SYNC_STAGES-1] && !trigPrev;

  // request queue
  logic             reqEvent, push, pop;
  logic [CNT_W-1:0] pendCnt;

  assign reqEvent  = trigEdge || (wrCtrl && cfgWdata[BIT_START]);
  assign pop       = strb.launch;
  assign push      = reqEvent && ((pendCnt != Q_FULL) || pop);
  assign pendValid = (pendCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendCnt <= '0;
    else if (softRst)      pendCnt <= '0;
    else if (push && !pop) pendCnt <= pendCnt + 1'b1;
    else if (pop && !push) pendCnt <= pendCnt - 1'b1;
  end

  // burst settings latched at launch
  logic              singleRun, calRun;
  logic [SLOT_W-1:0] chanRun, slot;
  logic [DELAY_W-1:0] delayCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleRun <= 1'b0;
      calRun    <= 1'b0;
      chanRun   <= '0;
      slot      <= '0;
      delayCnt  <= '0;
    end else begin
      if (strb.launch) begin
        singleRun <= singleCfg;
        calRun    <= calBit;
        chanRun   <= chanCfg;
        slot      <= '0;
      end else if (strb.advance) begin
        slot <= slot + 1'b1;
      end
      if (strb.loadDelay)      delayCnt <= delayCfg;
      else if (strb.countDown) delayCnt <= delayCnt - 1'b1;
    end
  end

  assign delayZero = (delayCnt == '0);
  assign lastSlot  = (slot == LAST_SLOT);

  // core handshake and result forwarding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStart <= 1'b0;
      convChan  <= '0;
      convCal   <= 1'b0;
      resWe     <= 1'b0;
      resSlot   <= '0;
      resData   <= '0;
    end else begin
      convStart <= strb.issue;
      convCal   <= strb.issue && calRun;
      if (strb.issue) convChan <= singleRun ? chanRun : slot;
      resWe <= strb.capture && !calRun;
      if (strb.capture) begin
        resSlot <= slot;
        resData <= convData;
      end
    end
  end

  // status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ascBit   <= 1'b0;
      calBit   <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (softRst)                                   ascBit <= 1'b0;
      else if (reqEvent)                             ascBit <= 1'b1;
      else if (strb.finish && pendCnt == '0)         ascBit <= 1'b0;

      if (softRst)                     calBit <= 1'b0;
      else if (wrCtrl)                 calBit <= cfgWdata[BIT_CAL];
      else if (strb.finish && calRun)  calBit <= 1'b0;

      if (strb.finish)                         doneFlag <= 1'b1;
      else if (wrCtrl && cfgWdata[BIT_CLR])    doneFlag <= 1'b0;
    end
  end

  assign irq = doneFlag && !maskCfg;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R1

  AST_RESULT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> $past(convDone)); // R1

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= Q_FULL); // R9

  AST_ASC_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && !softRst) |-> ascBit); // R4

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(wrCtrl && cfgWdata[BIT_CLR])) |=> doneFlag); // R8

  AST_CAL_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && seqBusy && calRun) |=> !resWe); // R7

endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
  import adc_burst_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int DATA_W      = 10,
  parameter int DELAY_W     = 8,
  parameter int QUEUE_DEPTH = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick32k,
  input  logic                         trigIn,
  input  logic                         cfgWe,
  input  logic                         cfgAddr,
  input  logic [REG_W-1:0]             cfgWdata,
  output logic                         convStart,
  output logic [$clog2(NUM_SLOTS)-1:0] convChan,
  output logic                         convCal,
  input  logic                         convDone,
  input  logic [DATA_W-1:0]            convData,
  output logic                         resWe,
  output logic [$clog2(NUM_SLOTS)-1:0] resSlot,
  output logic [DATA_W-1:0]            resData,
  output logic                         ascBit,
  output logic                         calBit,
  output logic                         doneFlag,
  output logic                         irq,
  output logic                         coreRst
);

  seqStrobe_t strb;
  logic softRst, pendValid, delayZero, lastSlot, gapEn, seqBusy;

  adc_burst_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .softRst   (softRst),
    .tick      (tick32k),
    .pendValid (pendValid),
    .delayZero (delayZero),
    .lastSlot  (lastSlot),
    .gapEn     (gapEn),
    .convDone  (convDone),
    .strb      (strb),
    .seqBusy   (seqBusy)
  );

  adc_burst_dpath #(
    .NUM_SLOTS   (NUM_SLOTS),
    .DATA_W      (DATA_W),
    .DELAY_W     (DELAY_W),
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .SYNC_STAGES (SYNC_STAGES),
    .REG_W       (REG_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .trigIn    (trigIn),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .convDone  (convDone),
    .convData  (convData),
    .strb      (strb),
    .seqBusy   (seqBusy),
    .softRst   (softRst),
    .pendValid (pendValid),
    .delayZero (delayZero),
    .lastSlot  (lastSlot),
    .gapEn     (gapEn),
    .convStart (convStart),
    .convChan  (convChan),
    .convCal   (convCal),
    .resWe     (resWe),
    .resSlot   (resSlot),
    .resData   (resData),
    .ascBit    (ascBit),
    .calBit    (calBit),
    .doneFlag  (doneFlag),
    .irq       (irq)
  );

  assign coreRst = softRst;

endmodule

// File: tb/tb_adc_burst_seq.sv
module tb_adc_burst_seq;

  localparam int TICK_PER = 16;

  logic        clk = 1'b0, rstN = 1'b0, tick32k = 1'b0, trigIn = 1'b0;
  logic        cfgWe = 1'b0, cfgAddr = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic        convDone = 1'b0;
  logic [9:0]  convData = '0;
  logic        convStart, convCal, resWe, ascBit, calBit, doneFlag, irq, coreRst;
  logic [2:0]  convChan, resSlot;
  logic [9:0]  resData;

  adc_burst_seq dut (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .trigIn(trigIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .convStart(convStart), .convChan(convChan), .convCal(convCal),
    .convDone(convDone), .convData(convData),
    .resWe(resWe), .resSlot(resSlot), .resData(resData),
    .ascBit(ascBit), .calBit(calBit), .doneFlag(doneFlag), .irq(irq),
    .coreRst(coreRst)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, tickSince = 0;
  int startCount = 0, calSeen = 0, rstSeen = 0, resCount = 0;
  int startTicks[$];
  logic [5:0] expQ[$];
  bit finished = 1'b0;
  bit shSingle = 0, shGap = 0, shMask = 0;
  logic [2:0] shChan = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // time base
  initial forever begin
    @(negedge clk);
    cyc     <= cyc + 1;
    tick32k <= ((cyc % TICK_PER) == TICK_PER - 1);
  end

  // converter core model
  initial forever begin
    @(negedge clk);
    if (convStart) begin
      logic [2:0] ch;
      ch = convChan;
      repeat (3) @(negedge clk);
      convData <= {ch, 7'(startCount)};
      convDone <= 1'b1;
      @(negedge clk);
      convDone <= 1'b0;
    end
  end

  // monitor and scoreboard
  initial forever begin
    @(negedge clk);
    if (convStart) begin
      startCount++;
      startTicks.push_back(tickSince);
      if (convCal) calSeen++;
    end
    if (coreRst) rstSeen++;
    if (resWe) begin
      resCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R1 R7 unexpected result", 1, 0);
      end else begin
        logic [5:0] item;
        item = expQ.pop_front();
        check(resSlot == item[5:3], "R1 slot order", resSlot, item[5:3]);
        check(resData[9:7] == item[2:0], "R2 R3 channel", resData[9:7], item[2:0]);
      end
    end
    if (convDone)     tickSince = 0;
    else if (tick32k) tickSince++;
  end

  task automatic align();
    do @(negedge clk); while ((cyc % TICK_PER) != 4);
  endtask

  task automatic writeReg(input bit a, input logic [15:0] d);
    cfgWe <= 1'b1; cfgAddr <= a; cfgWdata <= d;
    @(negedge clk);
    cfgWe <= 1'b0;
  endtask

  function automatic logic [15:0] ctrlWord(input bit st, input bit cal, input bit rs, input bit clr);
    logic [15:0] w;
    w = '0;
    w[0] = st; w[1] = cal; w[2] = shSingle; w[3] = shGap;
    w[4] = rs; w[5] = shMask; w[6] = clr; w[10:8] = shChan;
    return w;
  endfunction

  task automatic expectBurst(input bit single, input logic [2:0] ch);
    for (int s = 0; s < 8; s++) expQ.push_back({3'(s), single ? ch : 3'(s)});
  endtask

  task automatic startReq();
    align();
    tickSince = 0;
    startTicks.delete();
    writeReg(1'b0, ctrlWord(1, 0, 0, 0));
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (ascBit && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int sc, rc;
    repeat (5) @(negedge clk);
    rstN <= 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check({ascBit, calBit, doneFlag, irq} == 4'b0, "R11 status after reset",
          {ascBit, calBit, doneFlag, irq}, 0);
    check({convStart, convCal, resWe, coreRst} == 4'b0, "R11 strobes after reset",
          {convStart, convCal, resWe, coreRst}, 0);

    // R2 sweep with nonzero channel select, default delay (R5), no gap (R6)
    shChan = 3'd5;
    startCount = 0;
    expectBurst(0, 3'd0);
    startReq();
    check(ascBit == 1'b1, "R4 asc set by write", ascBit, 1);
    waitIdle();
    check(startCount == 8, "R1 eight starts", startCount, 8);
    check(startTicks.size() > 3 && startTicks[0] == 1, "R5 default delay ticks",
          startTicks.size() > 0 ? startTicks[0] : -1, 1);
    check(startTicks.size() > 3 && startTicks[3] == 0, "R6 no gap wait",
          startTicks.size() > 3 ? startTicks[3] : -1, 0);
    check(expQ.size() == 0, "R2 all results seen", expQ.size(), 0);
    check(ascBit == 1'b0, "R4 asc self clears", ascBit, 0);
    check(doneFlag == 1'b1, "R8 done flag set", doneFlag, 1);
    check(irq == 1'b1, "R8 irq unmasked", irq, 1);

    // R8 clear by writing 1
    align();
    writeReg(1'b0, ctrlWord(0, 0, 0, 1));
    @(negedge clk);
    check(doneFlag == 1'b0 && irq == 1'b0, "R8 done clear", doneFlag, 0);

    // R3 single channel via trigger, delay code 3
    writeReg(1'b1, 16'd3);
    shSingle = 1; shChan = 3'd6;
    writeReg(1'b0, ctrlWord(0, 0, 0, 0));
    startCount = 0;
    expectBurst(1, 3'd6);
    align();
    tickSince = 0;
    startTicks.delete();
    trigIn <= 1'b1;
    begin
      int n;
      n = 0;
      while (!ascBit && n < 20) begin @(negedge clk); n++; end
    end
    check(ascBit == 1'b1, "R4 asc set by trigger", ascBit, 1);
    trigIn <= 1'b0;
    waitIdle();
    check(startCount == 8, "R3 eight starts", startCount, 8);
    check(startTicks.size() > 5 && startTicks[0] == 4, "R5 delay code 3",
          startTicks.size() > 0 ? startTicks[0] : -1, 4);
    check(expQ.size() == 0, "R3 single channel results", expQ.size(), 0);

    // R6 gap mode with delay code 2
    writeReg(1'b1, 16'd2);
    shSingle = 0; shGap = 1; shChan = 3'd0;
    writeReg(1'b0, ctrlWord(0, 0, 0, 0));
    expectBurst(0, 3'd0);
    startReq();
    waitIdle();
    for (int i = 0; i < 8; i++)
      check(startTicks.size() == 8 && startTicks[i] == 3, "R6 gap ticks",
            startTicks.size() > i ? startTicks[i] : -1, 3);

    // R8 mask
    writeReg(1'b1, 16'd0);
    shGap = 0; shMask = 1;
    writeReg(1'b0, ctrlWord(0, 0, 0, 1));
    @(negedge clk);
    check(doneFlag == 1'b0, "R8 cleared before masked run", doneFlag, 0);
    expectBurst(0, 3'd0);
    startReq();
    waitIdle();
    check(doneFlag == 1'b1, "R8 flag set while masked", doneFlag, 1);
    check(irq == 1'b0, "R8 irq masked", irq, 0);

    // R7 calibration burst
    startCount = 0; calSeen = 0; rc = resCount;
    align();
    writeReg(1'b0, ctrlWord(1, 1, 0, 0));
    check(calBit == 1'b1, "R7 cal bit set", calBit, 1);
    waitIdle();
    check(calSeen == 8 && startCount == 8, "R7 cal starts", calSeen, 8);
    check(resCount == rc, "R7 no results", resCount - rc, 0);
    check(calBit == 1'b0, "R7 cal self clears", calBit, 0);
    check(doneFlag == 1'b1, "R7 done after cal", doneFlag, 1);

    // R9 queue: four back-to-back requests, three bursts run
    startCount = 0;
    expectBurst(0, 3'd0); expectBurst(0, 3'd0); expectBurst(0, 3'd0);
    align();
    cfgWe <= 1'b1; cfgAddr <= 1'b0; cfgWdata <= ctrlWord(1, 0, 0, 0);
    repeat (4) @(negedge clk);
    cfgWe <= 1'b0;
    waitIdle();
    check(startCount == 24, "R9 queued bursts", startCount, 24);
    check(expQ.size() == 0, "R9 queued results", expQ.size(), 0);

    // R10 core reset during gap wait with a request pending
    shGap = 1;
    writeReg(1'b1, 16'd5);
    writeReg(1'b0, ctrlWord(0, 0, 0, 0));
    rstSeen = 0;
    rc = resCount;
    expectBurst(0, 3'd0);
    startReq();
    begin
      int n;
      n = 0;
      while (resCount == rc && n < 2000) begin @(negedge clk); n++; end
    end
    writeReg(1'b0, ctrlWord(1, 0, 0, 0));
    writeReg(1'b0, ctrlWord(0, 0, 1, 0));
    repeat (3) @(negedge clk);
    expQ.delete();
    check(rstSeen == 1, "R10 reset pulse", rstSeen, 1);
    check(ascBit == 1'b0, "R10 asc cleared", ascBit, 0);
    sc = startCount;
    repeat (300) @(negedge clk);
    check(startCount == sc, "R10 sequencer idle", startCount - sc, 0);
    expectBurst(0, 3'd0);
    startReq();
    begin
      int n;
      n = 0;
      while (startTicks.size() == 0 && n < 2000) begin @(negedge clk); n++; end
    end
    check(startTicks.size() > 0 && startTicks[0] == 6, "R10 delay kept",
          startTicks.size() > 0 ? startTicks[0] : -1, 6);
    waitIdle();
    check(expQ.size() == 0, "R10 burst after reset", expQ.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule